// File: doc/BRIEF.md
# Oversampled Serial-Stream Edge Timestamper

This block turns a raw oversampled line into time measurements. A serial receiver, locked to the reference clock and with its line decoding bypassed, hands over one parallel word of `SAMPLES` raw line samples per reference cycle. With the default of 16 samples per 6.4 ns word, each sample stands for 400 ps. The first sample in time is in the most significant bit. A free-running coarse counter counts the words. The block finds each rising transition in the sample stream. It takes the fine offset from the sample index of the transition within its word, and it counts the high samples that follow until the line drops, even when the pulse runs across many words.

For each pulse, the block emits one packed record on a single-cycle strobe. The record holds the coarse count of the word where the pulse began, the fine offset, the width in samples, and a flag that marks a width that did not fit its field. Neither side of the block carries a ready signal, because the line cannot be paused. A word with `in_valid` low is skipped entirely. A record is offered for exactly one cycle, and a consumer that wants it must capture it in that cycle.

Top module: `tdc_edge_stamp`

## Requirements
- R1: The coarse counter is 0 for the first word accepted after reset and goes up by one for each accepted word. A record's coarse field is the counter value of the word that holds the pulse's first high sample.
- R2: The fine field gives the sample index of the rising transition within its word, counted from the most significant bit (index 0). This is the number of low samples in that word ahead of the transition, so 0x0FFE gives fine 4.
- R3: The width field counts the consecutive high samples of one pulse, and this count may span any number of words. For example, 0xFFFF followed by 0xF800 gives width 21.
- R4: If a word is all low and the transition falls in the next word, the coarse field is the later word's count, and the fine field is measured inside the later word.
- R5: A pulse that is one sample long is reported with width 1.
- R6: A pulse ends at the first low sample after its run. `out_valid` is high for one cycle, in the cycle right after the clock edge that accepts the word holding that low sample. In all other cycles, `out_valid` is low.
- R7: A rising transition later in the same word, after a pulse has ended, begins a new measurement. Only the first pulse that ends in a given word produces a record. A second pulse that both starts and ends in that same word is dropped. A pulse still open at the end of the word is kept.
- R8: If a pulse holds more high samples than the width field can count, the width field holds its maximum value (255 by default) and the saturation flag is 1. Otherwise the flag is 0.
- R9: A synchronous reset clears the coarse counter and `out_valid`, and it drops any pulse in progress. After reset, a leading high sample starts a fresh pulse.
- R10: A cycle with `in_valid` low has no effect. The counter holds its value, the pulse state is kept, and no record is made.
- R11: The `out_record` layout with default parameters is as follows. Bit 0 is the saturation flag, bits 8:1 are the width, bits 12:9 are the fine offset, and bits 28:13 are the coarse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one word per cycle |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The word on `in_word` is a real line word |
| in_word | input | SAMPLES | Raw line samples, earliest sample in the MSB |
| out_valid | output | 1 | One-cycle strobe for `out_record` |
| out_record | output | COARSE_W+FINE_W+WIDTH_W+1 | Packed {coarse, fine, width, saturated} |

## Verification
A pulse contained inside one word checks the fine offset and the in-word count. Pulses that run across two and three words, including one that starts on the last sample, show whether the width carries across word boundaries and whether the start time is held while the pulse is open. A quiet word ahead of an edge shows whether the coarse count moves forward. A one-sample pulse and a word that holds three pulses cover the minimum width and the first-record rule. Stalls in the middle of a pulse, a pulse of 240 samples next to one of 272 samples, and a reset in the middle of a pulse cover the skip rule, the saturation boundary and the discard of a pulse in progress.

// File: rtl/tdc_stamp_pkg.sv
package tdc_stamp_pkg;
  localparam int DEF_SAMPLES  = 16;
  localparam int DEF_COARSE_W = 16;
  localparam int DEF_WIDTH_W  = 8;

  typedef enum logic {
    LINE_QUIET = 1'b0,
    LINE_HIGH  = 1'b1
  } line_state_e;
endpackage

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
  parameter int COARSE_W = tdc_stamp_pkg::DEF_COARSE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  output logic [COARSE_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (adv) count <= count + COARSE_W'(1);
  end

  assert_coarse_step_R1: assert property (@(posedge clk) disable iff (rst)
    adv |=> (count == $past(count) + COARSE_W'(1)));
  assert_coarse_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(count));
endmodule

// File: rtl/tdc_word_scan.sv
module tdc_word_scan #(
  parameter int SAMPLES = tdc_stamp_pkg::DEF_SAMPLES,
  localparam int POS_W  = $clog2(SAMPLES),
  localparam int CNT_W  = $clog2(SAMPLES + 1)
) (
  input  logic [SAMPLES-1:0] word,
  input  logic               carry_in,
  output logic               rec_hit,
  output logic               rec_from_carry,
  output logic [POS_W-1:0]   rec_pos,
  output logic [CNT_W-1:0]   rec_ones,
  output logic               open_run,
  output logic               open_from_carry,
  output logic [POS_W-1:0]   open_pos,
  output logic [CNT_W-1:0]   open_ones
);
  logic             s_run, s_carry, s_done, s_bit;
  logic [POS_W-1:0] s_pos;
  logic [CNT_W-1:0] s_ones;

  always_comb begin
    s_run          = carry_in;
    s_carry        = carry_in;
    s_done         = 1'b0;
    s_pos          = '0;
    s_ones         = '0;
    s_bit          = 1'b0;
    rec_from_carry = 1'b0;
    rec_pos        = '0;
    rec_ones       = '0;
    for (int i = 0; i < SAMPLES; i++) begin
      s_bit = word[SAMPLES-1-i];
      if (s_run) begin
        if (s_bit) begin
          s_ones = s_ones + CNT_W'(1);
        end else begin
          if (!s_done) begin
            s_done         = 1'b1;
            rec_from_carry = s_carry;
            rec_pos        = s_pos;
            rec_ones       = s_ones;
          end
          s_run   = 1'b0;
          s_carry = 1'b0;
        end
      end else if (s_bit) begin
        s_run   = 1'b1;
        s_carry = 1'b0;
        s_pos   = POS_W'(i);
        s_ones  = CNT_W'(1);
      end
    end
    rec_hit         = s_done;
    open_run        = s_run;
    open_from_carry = s_carry;
    open_pos        = s_pos;
    open_ones       = s_ones;
  end
endmodule

// File: rtl/tdc_rec_out.sv
module tdc_rec_out #(
  parameter int COARSE_W = tdc_stamp_pkg::DEF_COARSE_W,
  parameter int FINE_W   = 4,
  parameter int WIDTH_W  = tdc_stamp_pkg::DEF_WIDTH_W,
  localparam int REC_W   = COARSE_W + FINE_W + WIDTH_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic [COARSE_W-1:0] coarse,
  input  logic [FINE_W-1:0]   fine,
  input  logic [WIDTH_W-1:0]  width,
  input  logic                sat,
  output logic                out_valid,
  output logic [REC_W-1:0]    out_record
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_record <= '0;
    end else begin
      out_valid <= fire;
      if (fire) out_record <= {coarse, fine, width, sat};
    end
  end

  assert_sat_full_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_record[0]) |-> (out_record[WIDTH_W:1] == {WIDTH_W{1'b1}}));
  assert_width_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_record[WIDTH_W:1] != '0));
  assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

// File: rtl/tdc_edge_stamp.sv
module tdc_edge_stamp
  import tdc_stamp_pkg::*;
#(
  parameter int SAMPLES  = DEF_SAMPLES,
  parameter int COARSE_W = DEF_COARSE_W,
  parameter int WIDTH_W  = DEF_WIDTH_W,
  localparam int FINE_W  = $clog2(SAMPLES),
  localparam int CNT_W   = $clog2(SAMPLES + 1),
  localparam int REC_W   = COARSE_W + FINE_W + WIDTH_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [SAMPLES-1:0] in_word,
  output logic               out_valid,
  output logic [REC_W-1:0]   out_record
);
  localparam int SUM_W = ((WIDTH_W > CNT_W) ? WIDTH_W : CNT_W) + 1;

  logic [COARSE_W-1:0] cnt;
  line_state_e         line_q;
  logic [WIDTH_W-1:0]  acc_q;
  logic                acc_sat_q;
  logic [COARSE_W-1:0] start_coarse_q;
  logic [FINE_W-1:0]   start_fine_q;

  logic               rec_hit, rec_from_carry, open_run, open_from_carry;
  logic [FINE_W-1:0]  rec_pos, open_pos;
  logic [CNT_W-1:0]   rec_ones, open_ones;

  logic [WIDTH_W:0]    rec_sum, open_sum;
  logic                fire;
  logic [COARSE_W-1:0] rec_coarse;
  logic [FINE_W-1:0]   rec_fine;
  logic [WIDTH_W-1:0]  rec_width;
  logic                rec_sat;

  function automatic logic [WIDTH_W:0] sat_add(logic [WIDTH_W-1:0] a,
                                               logic [CNT_W-1:0] b);
    logic [SUM_W-1:0] s;
    s = SUM_W'(a) + SUM_W'(b);
    if (s > SUM_W'({WIDTH_W{1'b1}})) return {1'b1, {WIDTH_W{1'b1}}};
    return {1'b0, s[WIDTH_W-1:0]};
  endfunction

  tdc_coarse_ctr #(.COARSE_W(COARSE_W)) u_ctr (
    .clk(clk), .rst(rst), .adv(in_valid), .count(cnt)
  );

  tdc_word_scan #(.SAMPLES(SAMPLES)) u_scan (
    .word(in_word),
    .carry_in(line_q == LINE_HIGH),
    .rec_hit(rec_hit),
    .rec_from_carry(rec_from_carry),
    .rec_pos(rec_pos),
    .rec_ones(rec_ones),
    .open_run(open_run),
    .open_from_carry(open_from_carry),
    .open_pos(open_pos),
    .open_ones(open_ones)
  );

  always_comb begin
    rec_sum  = sat_add(rec_from_carry ? acc_q : '0, rec_ones);
    open_sum = sat_add(open_from_carry ? acc_q : '0, open_ones);
    fire       = in_valid && rec_hit;
    rec_coarse = rec_from_carry ? start_coarse_q : cnt;
    rec_fine   = rec_from_carry ? start_fine_q : rec_pos;
    rec_width  = rec_sum[WIDTH_W-1:0];
    rec_sat    = rec_sum[WIDTH_W] || (rec_from_carry && acc_sat_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q         <= LINE_QUIET;
      acc_q          <= '0;
      acc_sat_q      <= 1'b0;
      start_coarse_q <= '0;
      start_fine_q   <= '0;
    end else if (in_valid) begin
      line_q <= open_run ? LINE_HIGH : LINE_QUIET;
      if (open_run) begin
        acc_q <= open_sum[WIDTH_W-1:0];
        if (open_from_carry) begin
          acc_sat_q <= acc_sat_q || open_sum[WIDTH_W];
        end else begin
          acc_sat_q      <= open_sum[WIDTH_W];
          start_coarse_q <= cnt;
          start_fine_q   <= open_pos;
        end
      end
    end
  end

  tdc_rec_out #(.COARSE_W(COARSE_W), .FINE_W(FINE_W), .WIDTH_W(WIDTH_W)) u_out (
    .clk(clk), .rst(rst), .fire(fire),
    .coarse(rec_coarse), .fine(rec_fine), .width(rec_width), .sat(rec_sat),
    .out_valid(out_valid), .out_record(out_record)
  );

  assert_valid_after_word_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  assert_open_keeps_start_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && line_q == LINE_HIGH && open_run && open_from_carry)
      |=> $stable(start_coarse_q));
endmodule

// File: tb/sim_tdc_edge_stamp.sv
module sim_tdc_edge_stamp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        out_valid;
  logic [28:0] out_record;

  int total = 0;
  int bad = 0;
  int wc = 0;
  bit finished = 1'b0;
  logic        got_v;
  logic [28:0] got_r;

  always #2 clk = ~clk;

  tdc_edge_stamp u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_record(out_record)
  );

  task automatic check_none(string req);
    total++;
    if (got_v !== 1'b0) begin
      bad++;
      $display("FAIL %s: out_valid=%b expected 0", req, got_v);
    end
  endtask

  // R11 layout: [28:13] coarse, [12:9] fine, [8:1] width, [0] saturated
  task automatic check_rec(string req, int coarse, int fine, int width, bit sat);
    logic [28:0] exp;
    exp = {16'(coarse), 4'(fine), 8'(width), sat};
    total++;
    if (got_v !== 1'b1 || got_r !== exp) begin
      bad++;
      $display("FAIL %s: valid=%b rec=%h expected valid=1 rec=%h", req, got_v, got_r, exp);
    end
  endtask

  task automatic send(logic [15:0] w);
    in_word = w;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    got_v = out_valid;
    got_r = out_record;
    wc++;
  endtask

  task automatic stall(int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b0;
      in_word = 16'hFFFF;
      @(posedge clk);
      @(negedge clk);
      got_v = out_valid;
      check_none("R10 stall");
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    got_v = out_valid;
    wc = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check_none("R9 reset");
    send(16'h0000);
    check_none("R6 quiet word");
  endtask

  task automatic t_in_word();
    int c;
    c = wc;
    send(16'h0FFE);
    check_rec("R2 in-word pulse", c, 4, 11, 1'b0);
  endtask

  task automatic t_span();
    int c;
    send(16'h0000);
    c = wc;
    send(16'hFFFF);
    check_none("R6 open pulse");
    send(16'hF800);
    check_rec("R4 R3 two-word pulse", c, 0, 21, 1'b0);
    c = wc;
    send(16'h0001);
    send(16'hFFFF);
    send(16'hF000);
    check_rec("R3 three-word pulse", c, 15, 21, 1'b0);
  endtask

  task automatic t_one_sample();
    int c;
    c = wc;
    send(16'h0800);
    check_rec("R5 single sample", c, 4, 1, 1'b0);
    c = wc;
    send(16'h0001);
    check_none("R6 last-sample open");
    send(16'h0000);
    check_rec("R5 single last sample", c, 15, 1, 1'b0);
  endtask

  task automatic t_multi();
    int c;
    c = wc;
    send(16'hC303);
    check_rec("R7 first pulse of word", c, 0, 2, 1'b0);
    send(16'h0000);
    check_rec("R7 later open pulse kept", c, 14, 2, 1'b0);
  endtask

  task automatic t_stall();
    int c;
    c = wc;
    send(16'h00FF);
    stall(3);
    send(16'h8000);
    check_rec("R10 pulse across stall", c, 8, 9, 1'b0);
    c = wc;
    send(16'h4000);
    check_rec("R1 count held in stall", c, 1, 1, 1'b0);
  endtask

  task automatic t_sat();
    int c;
    c = wc;
    for (int k = 0; k < 15; k++) send(16'hFFFF);
    send(16'h0000);
    check_rec("R8 240 no saturation", c, 0, 240, 1'b0);
    c = wc;
    for (int k = 0; k < 17; k++) send(16'hFFFF);
    send(16'h0000);
    check_rec("R8 272 saturated", c, 0, 255, 1'b1);
  endtask

  task automatic t_reset_mid();
    send(16'h00FF);
    do_reset();
    check_none("R9 reset drops pulse");
    send(16'h8000);
    check_rec("R9 R1 fresh after reset", 0, 0, 1, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_in_word();
    t_span();
    t_one_sample();
    t_multi();
    t_stall();
    t_sat();
    t_reset_mid();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule